// File: doc/BRIEF.md
# Software Transfer Activation Register

This block is an 8-bit control register that lets software start one data transfer on a transfer engine and pick the vector number for that request. The top bit is the activation enable. The lower seven bits hold the vector. Software sets the enable through a plain register write. The block then asks the engine for service and passes the vector along with the request.

The engine reports back to the block. It signals when a transfer is in progress, when one software-started transfer is done, whether the transfer count has run out, and the current value of its interrupt-disable select flag. From these inputs the block decides what happens to the enable bit:

- It clears the enable bit by itself when the transfer finishes normally.
- Otherwise it holds the enable bit and raises an end-of-transfer interrupt request. The request stays up until software writes 0 to the engine's select flag.

A synchronous standby input returns everything to zero, in the same way as reset.

Internally the behaviour is a four-state machine:

- **IDLE**: enable is 0.
- **ARMED**: enable is 1 and the request is offered.
- **XFER**: the engine is busy with the software transfer.
- **HOLD**: enable is 1 and the end interrupt is pending.

Its transitions are:

- **SET**: IDLE→ARMED.
- **START**: ARMED→XFER.
- **AUTOCLR**: ARMED/XFER→IDLE.
- **KEEP**: ARMED/XFER→HOLD.
- **RELEASE**: HOLD→IDLE.
- **REARM**: HOLD→ARMED, and ARMED/XFER→ARMED when a set coincides with an automatic clear.
- **STANDBY**: any state→IDLE.

Top module: `swact_reg`

## Requirements
- R1: After reset, the read data is 0x00 and the request and interrupt outputs are 0.
- R2: When standby is high at a clock edge, the register becomes 0x00, the interrupt clears, and any write in that cycle is dropped.
- R3: A write with bit 7 = 1 sets the enable bit. A write with bit 7 = 0 never clears it.
- R4: Bits 6..0 take the written value only while the enable bit is 0. While the enable bit is 1, writes leave those bits unchanged.
- R5: The read data is {enable, vector[6:0]}, with the enable bit in bit 7.
- R6: While a software transfer is in progress, the enable bit stays 1 and the request output is 0.
- R7: When the engine reports a software transfer done, the count is not exhausted and the select flag is 0, the enable bit clears on the next edge.
- R8: When a software transfer is done with the count exhausted or the select flag = 1, the enable bit stays 1 and the end interrupt goes to 1 and holds.
- R9: While the end interrupt is pending, a pulse reporting that 0 was written to the select flag clears both the enable bit and the interrupt.
- R10: The request output equals the enable bit while the engine is not busy and no end interrupt is pending. The vector output always equals bits 6..0.
- R11: When a write with bit 7 = 1 lands in the same cycle as a hardware clear, the enable bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Synchronous clear to the reset state |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data {enable, vector} |
| eng_busy | input | 1 | Engine is running a transfer |
| eng_sw_done | input | 1 | One software-started transfer finished (pulse) |
| eng_cnt_zero | input | 1 | Transfer count exhausted |
| eng_irq_sel | input | 1 | Engine interrupt-disable select flag |
| sel_zero_wr | input | 1 | Pulse: software wrote 0 to the select flag |
| sw_req | output | 1 | Software activation request to the engine |
| sw_vec | output | 7 | Vector number for the request |
| sw_end_irq | output | 1 | Software transfer-end interrupt request |

## Verification
A transfer completion is driven under each combination of the two status inputs: select flag 0 with count remaining, select flag 1, and count exhausted. These runs separate automatic clearing from the held-with-interrupt path. Vector writes are issued both with the enable bit clear and with it set, and set writes are issued with bit 7 at 0 and at 1, which tells locking apart from write-one-only behaviour. A set write is made to coincide with an automatic clear, and with the release pulse, to show which one wins. Standby is applied while the interrupt is pending.

// File: rtl/swact_pkg.sv
package swact_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_XFER  = 2'd2,
        ST_HOLD  = 2'd3
    } swact_state_e;
endpackage

// File: rtl/swact_vec_field.sv
module swact_vec_field #(
    parameter int VEC_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby,
    input  logic             wr,
    input  logic             locked,
    input  logic [VEC_W-1:0] wdata,
    output logic [VEC_W-1:0] vec
);
    logic [VEC_W-1:0] vec_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (standby) begin
            vec_q <= '0;
        end else if (wr && !locked) begin
            vec_q <= wdata;
        end
    end

    assign vec = vec_q;
endmodule

// File: rtl/swact_fsm.sv
module swact_fsm
    import swact_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic standby,
    input  logic set_req,
    input  logic busy,
    input  logic done,
    input  logic cnt_zero,
    input  logic irq_sel,
    input  logic sel_zero_wr,
    output logic enable,
    output logic req,
    output logic end_irq
);
    swact_state_e state_q, state_d;
    logic         keep_after_done;

    assign keep_after_done = cnt_zero || irq_sel;

    always_comb begin
        state_d = state_q;
        if (standby) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (set_req) state_d = ST_ARMED;
                end
                ST_ARMED, ST_XFER: begin
                    if (done) begin
                        if (keep_after_done) state_d = ST_HOLD;
                        else if (set_req)    state_d = ST_ARMED;
                        else                 state_d = ST_IDLE;
                    end else if (busy) begin
                        state_d = ST_XFER;
                    end
                end
                ST_HOLD: begin
                    if (sel_zero_wr) state_d = set_req ? ST_ARMED : ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        enable  = 1'b0;
        req     = 1'b0;
        end_irq = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ARMED: begin
                enable = 1'b1;
                req    = !busy;
            end
            ST_XFER: enable = 1'b1;
            ST_HOLD: begin
                enable  = 1'b1;
                end_irq = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/swact_reg.sv
module swact_reg #(
    parameter int VEC_W = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           standby,
    input  logic           reg_wr,
    input  logic [VEC_W:0] reg_wdata,
    output logic [VEC_W:0] reg_rdata,
    input  logic           eng_busy,
    input  logic           eng_sw_done,
    input  logic           eng_cnt_zero,
    input  logic           eng_irq_sel,
    input  logic           sel_zero_wr,
    output logic           sw_req,
    output logic [VEC_W-1:0] sw_vec,
    output logic           sw_end_irq
);
    localparam int EN_BIT = VEC_W;

    logic enable;
    logic set_req;

    assign set_req = reg_wr && reg_wdata[EN_BIT];

    swact_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .standby    (standby),
        .set_req    (set_req),
        .busy       (eng_busy),
        .done       (eng_sw_done),
        .cnt_zero   (eng_cnt_zero),
        .irq_sel    (eng_irq_sel),
        .sel_zero_wr(sel_zero_wr),
        .enable     (enable),
        .req        (sw_req),
        .end_irq    (sw_end_irq)
    );

    swact_vec_field #(.VEC_W(VEC_W)) vec_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .standby(standby),
        .wr     (reg_wr),
        .locked (enable),
        .wdata  (reg_wdata[VEC_W-1:0]),
        .vec    (sw_vec)
    );

    assign reg_rdata = {enable, sw_vec};
endmodule

// File: rtl/swact_chk.sv
module swact_chk #(
    parameter int VEC_W = 7
) (
    input logic           clk,
    input logic           rst_n,
    input logic           standby,
    input logic           reg_wr,
    input logic [VEC_W:0] reg_wdata,
    input logic [VEC_W:0] reg_rdata,
    input logic           eng_busy,
    input logic           eng_sw_done,
    input logic           eng_cnt_zero,
    input logic           eng_irq_sel,
    input logic           sel_zero_wr,
    input logic           sw_req,
    input logic [VEC_W-1:0] sw_vec,
    input logic           sw_end_irq
);
    logic en;
    assign en = reg_rdata[VEC_W];

    // R2
    standby_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (reg_rdata == '0 && !sw_end_irq));

    // R3
    zero_write_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && reg_wr && !reg_wdata[VEC_W] && !eng_sw_done && !sel_zero_wr && !standby) |=> en);

    // R4
    vec_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !standby) |=> $stable(sw_vec));

    // R6
    busy_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |-> !sw_req);

    // R7
    auto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sw_end_irq && eng_sw_done && !eng_irq_sel && !eng_cnt_zero
         && !(reg_wr && reg_wdata[VEC_W]) && !standby) |=> !en);

    // R8
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_end_irq |-> en);

    // R10
    req_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_req |-> (en && !sw_end_irq));
endmodule

bind swact_reg swact_chk #(.VEC_W(VEC_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .standby(standby), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_busy(eng_busy),
    .eng_sw_done(eng_sw_done), .eng_cnt_zero(eng_cnt_zero),
    .eng_irq_sel(eng_irq_sel), .sel_zero_wr(sel_zero_wr),
    .sw_req(sw_req), .sw_vec(sw_vec), .sw_end_irq(sw_end_irq)
);

// File: tb/swact_reg_tb.sv
module swact_reg_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       eng_busy = 1'b0;
    logic       eng_sw_done = 1'b0;
    logic       eng_cnt_zero = 1'b0;
    logic       eng_irq_sel = 1'b0;
    logic       sel_zero_wr = 1'b0;
    logic       sw_req;
    logic [6:0] sw_vec;
    logic       sw_end_irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    swact_reg dut_i (
        .clk(clk), .rst_n(rst_n), .standby(standby), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_busy(eng_busy),
        .eng_sw_done(eng_sw_done), .eng_cnt_zero(eng_cnt_zero),
        .eng_irq_sel(eng_irq_sel), .sel_zero_wr(sel_zero_wr),
        .sw_req(sw_req), .sw_vec(sw_vec), .sw_end_irq(sw_end_irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic done_pulse(input logic cz, input logic sel);
        eng_cnt_zero = cz; eng_irq_sel = sel; eng_sw_done = 1'b1;
        tick();
        eng_sw_done = 1'b0; eng_busy = 1'b0;
    endtask

    task automatic release_pulse();
        eng_irq_sel = 1'b0; sel_zero_wr = 1'b1;
        tick();
        sel_zero_wr = 1'b0; eng_cnt_zero = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rdata", reg_rdata, 8'h00);
        chk("R1 req/irq", {6'd0, sw_req, sw_end_irq}, 8'h00);
    endtask

    task automatic t_set_and_lock();
        wr(8'h85);
        chk("R3 set", reg_rdata, 8'h85);
        chk("R10 req", {7'd0, sw_req}, 8'h01);
        chk("R10 vec", {1'b0, sw_vec}, 8'h05);
        wr(8'h22);
        chk("R4 lock / R3 zero write", reg_rdata, 8'h85);
    endtask

    task automatic t_transfer_autoclear();
        eng_busy = 1'b1;
        tick();
        chk("R6 busy", {sw_req, reg_rdata[7]}, 8'h01);
        done_pulse(1'b0, 1'b0);
        chk("R7 autoclear", reg_rdata, 8'h05);
        chk("R7 no irq", {7'd0, sw_end_irq}, 8'h00);
    endtask

    task automatic t_vec_open();
        wr(8'h7F);
        chk("R4 open write", reg_rdata, 8'h7F);
        chk("R5 read", {1'b0, sw_vec}, 8'h7F);
        wr(8'h00);
        chk("R4 clear write", reg_rdata, 8'h00);
    endtask

    task automatic t_hold_sel();
        wr(8'h93);
        eng_busy = 1'b1;
        tick();
        done_pulse(1'b0, 1'b1);
        chk("R8 held sel", reg_rdata, 8'h93);
        chk("R8 irq sel", {sw_end_irq, sw_req}, 8'h02);
        tick();
        chk("R8 irq holds", {7'd0, sw_end_irq}, 8'h01);
        release_pulse();
        chk("R9 release", {sw_end_irq, reg_rdata[7]}, 8'h00);
    endtask

    task automatic t_hold_cnt();
        wr(8'hC4);
        done_pulse(1'b1, 1'b0);
        chk("R8 held cnt", reg_rdata, 8'hC4);
        chk("R8 irq cnt", {7'd0, sw_end_irq}, 8'h01);
        release_pulse();
        chk("R9 release cnt", reg_rdata, 8'h44);
    endtask

    task automatic t_set_wins();
        wr(8'h81);
        reg_wr = 1'b1; reg_wdata = 8'h80;
        done_pulse(1'b0, 1'b0);
        reg_wr = 1'b0; reg_wdata = '0;
        chk("R11 set wins", reg_rdata, 8'h81);
        chk("R11 req", {7'd0, sw_req}, 8'h01);
        done_pulse(1'b0, 1'b0);
        chk("R7 clear after", reg_rdata, 8'h01);
    endtask

    task automatic t_standby();
        wr(8'h9A);
        done_pulse(1'b1, 1'b1);
        chk("R8 pre-standby", {7'd0, sw_end_irq}, 8'h01);
        standby = 1'b1; reg_wr = 1'b1; reg_wdata = 8'hFF;
        tick();
        standby = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        eng_cnt_zero = 1'b0; eng_irq_sel = 1'b0;
        chk("R2 standby", reg_rdata, 8'h00);
        chk("R2 irq", {7'd0, sw_end_irq}, 8'h00);
    endtask

    initial begin
        #20000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        t_reset();
        t_set_and_lock();
        t_transfer_autoclear();
        t_vec_open();
        t_hold_sel();
        t_hold_cnt();
        t_set_wins();
        t_standby();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule